// File: doc/BRIEF.md
# Phase-State Instruction Processor Core

This block is a small multi-cycle processor. Its data words are not binary numbers: each of its sixteen registers holds one of four phase states, Φ0 to Φ3, coded in two bits. The arithmetic unit has a single operation, compose, defined as addition modulo 4 of the two codes. The core reads 16-bit instructions through a synchronous instruction-memory port with an 8-bit address. It writes 2-bit phase values through a data-memory write port that also has an 8-bit address.

Every instruction word uses one layout. The opcode sits in [15:12] and a register number in [11:8]. The low byte [7:0] holds either two source register numbers ([7:4] and [3:0]), an address, or a call identifier, depending on the opcode. Each instruction takes two clock cycles: a fetch cycle, in which the memory returns the word at the program counter, and an execute cycle.

A system call raises a one-cycle strobe together with its identifier and moves the core into the kernel phase. The core then waits until the kernel asserts a resume input. A halt moves the core into the kernel phase permanently, until the next reset.

Top module: `phase_core`

## Requirements
- R1: After synchronous reset, imem_addr is 0, halted, sys_valid and dmem_we are 0, core_phase is 2 (running), and every register holds Φ0 (code 0).
- R2: imem_addr always equals the program counter. Each instruction takes exactly two clock edges, fetch then execute. The counter advances by one and wraps from 0xFF to 0x00.
- R3: LOAD (opcode 0x0) writes bits [1:0] of the instruction into the register named by [11:8]. Bits [7:2] are ignored.
- R4: COMP (opcode 0x2) writes (reg[7:4] + reg[3:0]) mod 4 into the register named by [11:8].
- R5: STORE (opcode 0x1) raises dmem_we for exactly one cycle, with dmem_addr = [7:0] and dmem_wdata = the register named by [11:8].
- R6: JMP (opcode 0x3) loads the program counter with [7:0].
- R7: JMPZ (opcode 0x4) loads the program counter with [7:0] when the register named by [11:8] holds Φ0. Otherwise the counter advances by one.
- R8: HALT (opcode 0x5) sets halted, which then stays set until reset. After a HALT, imem_addr stays at the HALT's own address, core_phase is 3, no further stores occur, and kernel_resume has no effect.
- R9: NOP (opcode 0x6) and opcodes 0x8 to 0xF change no register and produce no store. They only advance the program counter.
- R10: SYS (opcode 0x7) pulses sys_valid for one cycle, drives sys_id = [7:0], and sets core_phase to 3. The core then stalls with imem_addr at the next address until kernel_resume is sampled high. After that, core_phase returns to 2 and execution continues.
- R11: kernel_resume has no effect while the core is not stalled after a SYS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 8 | Instruction fetch address (the program counter) |
| imem_rdata | input | 16 | Instruction word, returned one cycle after the address |
| dmem_we | output | 1 | Data-memory write strobe |
| dmem_addr | output | 8 | Data-memory write address |
| dmem_wdata | output | 2 | Phase value written |
| kernel_resume | input | 1 | Kernel releases a core stalled after SYS |
| sys_valid | output | 1 | One-cycle system-call strobe |
| sys_id | output | 8 | Call identifier of the last SYS |
| halted | output | 1 | Core has executed HALT |
| core_phase | output | 2 | 2 while running, 3 while in the kernel phase |

## Verification
The register file can only be seen through STORE. A corrupted or unreset register therefore appears as a wrong dmem_wdata at the first store that names it. It can also appear as a wrong branch choice at the next JMPZ, visible on imem_addr within two cycles. A wrong program counter or a control state that skips a cycle shows up on imem_addr, and on when halted or sys_valid rises, at an exact edge count after reset. The directed programs are laid out so that a misdecoded opcode either emits an extra store to a marker address or stores a different phase value.

// File: rtl/phase_pkg.sv
package phase_pkg;
  localparam int INSTR_W = 16;
  localparam int FIELD_W = 4;
  localparam int PHASE_W = 2;

  typedef logic [PHASE_W-1:0] phase_t;

  localparam phase_t PH_GROUND = 2'd0;
  localparam phase_t PH_RUN    = 2'd2;
  localparam phase_t PH_KERNEL = 2'd3;

  typedef enum logic [FIELD_W-1:0] {
    OP_LOAD  = 4'h0,
    OP_STORE = 4'h1,
    OP_COMP  = 4'h2,
    OP_JMP   = 4'h3,
    OP_JMPZ  = 4'h4,
    OP_HALT  = 4'h5,
    OP_NOP   = 4'h6,
    OP_SYS   = 4'h7
  } opcode_e;

  typedef struct packed {
    logic [FIELD_W-1:0] op;
    logic [FIELD_W-1:0] rd;
    logic [FIELD_W-1:0] rs1;
    logic [FIELD_W-1:0] rs2;
  } instr_t;

  typedef enum logic [1:0] {
    ST_FETCH   = 2'd0,
    ST_EXEC    = 2'd1,
    ST_SYSWAIT = 2'd2,
    ST_HALT    = 2'd3
  } core_state_e;
endpackage

// File: rtl/phase_compose.sv
module phase_compose
  import phase_pkg::*;
(
  input  phase_t a,
  input  phase_t b,
  output phase_t y
);
  // Compose: addition modulo the number of phase states (wraps in PHASE_W bits).
  assign y = phase_t'(a + b);

  always_comb begin
    assert (y == phase_t'((int'(a) + int'(b)) % 4))
      else $error("compose result out of ring (R4)");
  end
endmodule

// File: rtl/phase_regfile.sv
module phase_regfile
  import phase_pkg::*;
#(
  parameter int NREG = 16,
  localparam int RA_W = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we,
  input  logic [RA_W-1:0] waddr,
  input  phase_t          wdata,
  input  logic [RA_W-1:0] ra_a,
  input  logic [RA_W-1:0] ra_b,
  input  logic [RA_W-1:0] ra_c,
  output phase_t          rd_a,
  output phase_t          rd_b,
  output phase_t          rd_c
);
  phase_t regs [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= PH_GROUND;
    end else if (we) begin
      regs[waddr] <= wdata;
    end
  end

  assign rd_a = regs[ra_a];
  assign rd_b = regs[ra_b];
  assign rd_c = regs[ra_c];

  // R3/R4: a write is visible on the next cycle
  p_write_lands_r3: assert property (@(posedge clk) disable iff (rst)
    we |=> regs[$past(waddr)] == $past(wdata));
endmodule

// File: rtl/phase_core.sv
module phase_core
  import phase_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int NREG   = 16,
  localparam int RA_W  = $clog2(NREG),
  localparam int ID_W  = 2 * FIELD_W
) (
  input  logic              clk,
  input  logic              rst,
  output logic [ADDR_W-1:0] imem_addr,
  input  logic [INSTR_W-1:0] imem_rdata,
  output logic              dmem_we,
  output logic [ADDR_W-1:0] dmem_addr,
  output logic [PHASE_W-1:0] dmem_wdata,
  input  logic              kernel_resume,
  output logic              sys_valid,
  output logic [ID_W-1:0]   sys_id,
  output logic              halted,
  output logic [PHASE_W-1:0] core_phase
);
  core_state_e       state;
  logic [ADDR_W-1:0] pc;
  instr_t            ir;
  opcode_e           op;
  logic [ADDR_W-1:0] target;
  phase_t            val_a, val_b, val_c, comp_y, wr_val;
  logic              rf_we;

  assign ir        = instr_t'(imem_rdata);
  assign op        = opcode_e'(ir.op);
  assign target    = ADDR_W'({ir.rs1, ir.rs2});
  assign imem_addr = pc;

  phase_regfile #(.NREG(NREG)) u_rf (
    .clk   (clk),
    .rst   (rst),
    .we    (rf_we),
    .waddr (ir.rd[RA_W-1:0]),
    .wdata (wr_val),
    .ra_a  (ir.rs1[RA_W-1:0]),
    .ra_b  (ir.rs2[RA_W-1:0]),
    .ra_c  (ir.rd[RA_W-1:0]),
    .rd_a  (val_a),
    .rd_b  (val_b),
    .rd_c  (val_c)
  );

  phase_compose u_alu (
    .a (val_a),
    .b (val_b),
    .y (comp_y)
  );

  always_comb begin
    rf_we  = (state == ST_EXEC) && (op == OP_LOAD || op == OP_COMP);
    wr_val = (op == OP_LOAD) ? phase_t'(ir.rs2[PHASE_W-1:0]) : comp_y;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_FETCH;
      pc         <= '0;
      dmem_we    <= 1'b0;
      dmem_addr  <= '0;
      dmem_wdata <= '0;
      sys_valid  <= 1'b0;
      sys_id     <= '0;
      halted     <= 1'b0;
      core_phase <= PH_RUN;
    end else begin
      dmem_we   <= 1'b0;
      sys_valid <= 1'b0;
      unique case (state)
        ST_FETCH: state <= ST_EXEC;
        ST_EXEC: begin
          state <= ST_FETCH;
          pc    <= pc + ADDR_W'(1);
          case (op)
            OP_STORE: begin
              dmem_we    <= 1'b1;
              dmem_addr  <= target;
              dmem_wdata <= val_c;
            end
            OP_JMP:  pc <= target;
            OP_JMPZ: if (val_c == PH_GROUND) pc <= target;
            OP_HALT: begin
              pc         <= pc;
              halted     <= 1'b1;
              state      <= ST_HALT;
              core_phase <= PH_KERNEL;
            end
            OP_SYS: begin
              sys_valid  <= 1'b1;
              sys_id     <= {ir.rs1, ir.rs2};
              state      <= ST_SYSWAIT;
              core_phase <= PH_KERNEL;
            end
            default: ;
          endcase
        end
        ST_SYSWAIT: begin
          if (kernel_resume) begin
            state      <= ST_FETCH;
            core_phase <= PH_RUN;
          end
        end
        ST_HALT: ;
        default: state <= ST_FETCH;
      endcase
    end
  end

  p_halt_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted && $stable(imem_addr) && !dmem_we);

  p_halt_kernel_r8: assert property (@(posedge clk) disable iff (rst)
    halted |-> core_phase == PH_KERNEL);

  p_sys_strobe_r10: assert property (@(posedge clk) disable iff (rst)
    sys_valid |=> !sys_valid);

  p_sys_kernel_r10: assert property (@(posedge clk) disable iff (rst)
    sys_valid |-> core_phase == PH_KERNEL);

  p_stall_holds_pc_r10: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SYSWAIT) |=> $stable(imem_addr));

  p_store_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    dmem_we |=> !dmem_we);

  p_fetch_no_store_r2: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FETCH) |=> !dmem_we && !sys_valid);
endmodule

// File: tb/sim_phase_core.sv
`timescale 1ns/1ps
module sim_phase_core;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  imem_addr;
  logic [15:0] imem_rdata;
  logic        dmem_we;
  logic [7:0]  dmem_addr;
  logic [1:0]  dmem_wdata;
  logic        kernel_resume = 1'b0;
  logic        sys_valid;
  logic [7:0]  sys_id;
  logic        halted;
  logic [1:0]  core_phase;

  int total = 0;
  int bad   = 0;

  logic [15:0] imem [256];
  int          st_cnt;
  logic [7:0]  st_addr [16];
  logic [1:0]  st_data [16];

  always #2 clk = ~clk;

  phase_core u0 (
    .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
    .dmem_we(dmem_we), .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata),
    .kernel_resume(kernel_resume), .sys_valid(sys_valid), .sys_id(sys_id),
    .halted(halted), .core_phase(core_phase)
  );

  always @(posedge clk) imem_rdata <= imem[imem_addr];

  always @(negedge clk) begin
    if (!rst && dmem_we && st_cnt < 16) begin
      st_addr[st_cnt] = dmem_addr;
      st_data[st_cnt] = dmem_wdata;
      st_cnt = st_cnt + 1;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clear_prog();
    for (int i = 0; i < 256; i++) imem[i] = 16'h5000;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    st_cnt = 0;
    rst = 1'b0;
  endtask

  task automatic run_to_halt(input string tag);
    int n = 0;
    while (!halted && n < 1000) begin
      @(negedge clk);
      n++;
    end
    check(halted == 1'b1, tag, halted, 1);
  endtask

  task automatic check_store(input int idx, input logic [7:0] a, input logic [1:0] d, input string tag);
    check(st_addr[idx] == a, tag, st_addr[idx], a);
    check(st_data[idx] == d, tag, st_data[idx], d);
  endtask

  // R3 R4 R11: loads, compose with wrap, resume held high throughout
  task automatic t_load_comp();
    clear_prog();
    imem[0] = 16'h0101; imem[1] = 16'h0203; imem[2] = 16'h0402;
    imem[3] = 16'h2312; imem[4] = 16'h2614; imem[5] = 16'h080E;
    imem[6] = 16'h2944; imem[7] = 16'h2B26;
    imem[8] = 16'h1320; imem[9] = 16'h1621; imem[10] = 16'h1822;
    imem[11] = 16'h1923; imem[12] = 16'h1B24; imem[13] = 16'h1125;
    kernel_resume = 1'b1;
    do_reset();
    run_to_halt("R11 halt reached with resume high");
    kernel_resume = 1'b0;
    check(st_cnt == 6, "R5 store count", st_cnt, 6);
    check_store(0, 8'h20, 2'd0, "R4 compose 1+3 wraps");
    check_store(1, 8'h21, 2'd3, "R4 compose 1+2");
    check_store(2, 8'h22, 2'd2, "R3 imm low bits only");
    check_store(3, 8'h23, 2'd0, "R4 compose 2+2");
    check_store(4, 8'h24, 2'd2, "R4 compose 3+3");
    check_store(5, 8'h25, 2'd1, "R3 load value");
  endtask

  // R1: reset values and register clear
  task automatic t_reset();
    clear_prog();
    imem[0] = 16'h1610; imem[1] = 16'h1B11;
    do_reset();
    check(imem_addr == 8'h00, "R1 pc reset", imem_addr, 0);
    check(halted == 1'b0, "R1 halted reset", halted, 0);
    check(sys_valid == 1'b0, "R1 sys_valid reset", sys_valid, 0);
    check(dmem_we == 1'b0, "R1 dmem_we reset", dmem_we, 0);
    check(core_phase == 2'd2, "R1 phase reset", core_phase, 2);
    run_to_halt("R1 halt reached");
    check(st_cnt == 2, "R1 store count", st_cnt, 2);
    check_store(0, 8'h10, 2'd0, "R1 r6 cleared");
    check_store(1, 8'h11, 2'd0, "R1 r11 cleared");
  endtask

  // R2 R9: two-cycle timing, NOP and unused opcodes
  task automatic t_nop_timing();
    clear_prog();
    imem[0] = 16'h0102; imem[1] = 16'h8123; imem[2] = 16'hF1FF;
    imem[3] = 16'h61FF; imem[4] = 16'h1140;
    do_reset();
    repeat (11) @(posedge clk);
    @(negedge clk);
    check(halted == 1'b0, "R2 not halted at edge 11", halted, 0);
    check(imem_addr == 8'h05, "R2 pc at edge 11", imem_addr, 5);
    @(posedge clk);
    @(negedge clk);
    check(halted == 1'b1, "R2 halted at edge 12", halted, 1);
    check(core_phase == 2'd3, "R8 kernel phase on halt", core_phase, 3);
    check(st_cnt == 1, "R9 only one store", st_cnt, 1);
    check_store(0, 8'h40, 2'd2, "R9 unused opcodes left r1");
  endtask

  // R6 R7: jumps and conditional branch both ways
  task automatic t_jump();
    clear_prog();
    imem[0] = 16'h3005;
    for (int i = 1; i < 5; i++) imem[i] = 16'h10EE;
    imem[5] = 16'h0101; imem[6] = 16'h4120; imem[7] = 16'h400A;
    imem[8] = 16'h10EE; imem[9] = 16'h10EE; imem[10] = 16'h1130;
    do_reset();
    run_to_halt("R6 halt reached");
    check(st_cnt == 1, "R7 jump path store count", st_cnt, 1);
    check_store(0, 8'h30, 2'd1, "R7 taken and not-taken branches");
  endtask

  // R2 R7 R8: counter wrap and halt behaviour
  task automatic t_wrap_halt();
    clear_prog();
    imem[0] = 16'h43FE; imem[8'hFE] = 16'h0301; imem[8'hFF] = 16'h6000;
    imem[1] = 16'h1350; imem[2] = 16'h5000;
    do_reset();
    run_to_halt("R2 wrap halt reached");
    check(st_cnt == 1, "R2 wrap store count", st_cnt, 1);
    check_store(0, 8'h50, 2'd1, "R2 wrap continued at 0");
    kernel_resume = 1'b1;
    repeat (5) @(negedge clk);
    kernel_resume = 1'b0;
    repeat (2) @(negedge clk);
    check(halted == 1'b1, "R8 halted sticky", halted, 1);
    check(imem_addr == 8'h02, "R8 pc frozen", imem_addr, 2);
    check(core_phase == 2'd3, "R8 phase stays kernel", core_phase, 3);
    check(st_cnt == 1, "R8 no store after halt", st_cnt, 1);
  endtask

  // R10: system call strobe, stall and resume
  task automatic t_sys();
    clear_prog();
    imem[0] = 16'h0103; imem[1] = 16'h705A; imem[2] = 16'h1160;
    do_reset();
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(sys_valid == 1'b1, "R10 strobe at edge 4", sys_valid, 1);
    check(sys_id == 8'h5A, "R10 call id", sys_id, 8'h5A);
    check(core_phase == 2'd3, "R10 kernel phase", core_phase, 3);
    check(imem_addr == 8'h02, "R10 pc next", imem_addr, 2);
    repeat (5) @(posedge clk);
    @(negedge clk);
    check(sys_valid == 1'b0, "R10 strobe one cycle", sys_valid, 0);
    check(imem_addr == 8'h02, "R10 stalled pc", imem_addr, 2);
    check(st_cnt == 0, "R10 no store while stalled", st_cnt, 0);
    check(halted == 1'b0, "R10 not halted while stalled", halted, 0);
    kernel_resume = 1'b1;
    @(posedge clk);
    @(negedge clk);
    kernel_resume = 1'b0;
    check(core_phase == 2'd2, "R10 phase back to running", core_phase, 2);
    run_to_halt("R10 halt after resume");
    check(st_cnt == 1, "R10 store count", st_cnt, 1);
    check_store(0, 8'h60, 2'd3, "R10 execution continued");
  endtask

  initial begin
    #80000;
    bad++;
    total++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    st_cnt = 0;
    clear_prog();
    t_load_comp();
    t_reset();
    t_nop_timing();
    t_jump();
    t_wrap_halt();
    t_sys();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule